// File: doc/BRIEF.md
# Interrupt Deactivation Gate

This block sits in a per-CPU interrupt interface and services writes to the deactivate-interrupt register. Each write carries an interrupt ID. Alongside the write, the block receives the context of the interrupt and of the processor:

- the interrupt's group;
- the global security-disable bit;
- the current exception level and security state;
- whether FIQ and IRQ are routed to the highest level;
- whether FIQ and IRQ are routed to the hypervisor level;
- whether the end-of-interrupt mode in force splits priority drop from deactivation.

From these it decides whether the write may end the interrupt's active state.

When the write is allowed, the block acts according to the ID. For the 32 interrupts local to the CPU it clears the bit in its own active register. For any other implemented ID it sends a one-cycle active-clear request, carrying the ID, towards the distributor. Any write that is not allowed leaves every output unchanged.

The local active bits are set from outside through a set vector. That vector is driven by the acknowledge path, which lives in a separate block.

Top module: `irq_deact_gate`

## Requirements
- R1: The ID is bits [23:0] of `wrData`, and bits above 23 have no effect. A write whose ID is at or above `NUM_IRQ` (default 256) is ignored: no local bit clears and no distributor request is made.
- R2: A write with `splitEoi` = 0 is ignored.
- R3: With `excLevel` = 3, every write that has an implemented ID, a valid group and split mode is allowed.
- R4: With `excLevel` = 2, a write is allowed in two cases only. The first is group 0 with `secDisable` = 1 and `el3FiqRoute` = 0. The second is a non-secure interrupt that is not group 0, with `el3IrqRoute` = 0. An interrupt counts as secure when `secDisable` = 0 and its group is not 2.
- R5: With `excLevel` = 1 and `curSecure` = 0, the R4 cases apply, with one further condition. The group 0 case also needs `el2FiqRoute` = 0, and the other case also needs `el2IrqRoute` = 0.
- R6: With `excLevel` = 1 and `curSecure` = 1, a write is allowed in two cases. The first is group 0 with `el3FiqRoute` = 0. The second is a group other than 0, with the interrupt non-secure or `secDisable` = 0, and `el3IrqRoute` = 0.
- R7: An allowed write with an ID below 32 clears `localActive[ID]` at the next clock edge and makes no distributor request.
- R8: An allowed write with an ID from 32 to `NUM_IRQ`-1 raises `distClrValid`, with `distClrId` = ID, for exactly the one cycle after the write edge.
- R9: Writes with `excLevel` = 0 or `intGroup` = 3 (reserved) are ignored. The group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R10: After reset, `localActive` is all zero and `distClrValid` is 0.
- R11: A bit set in `localActSet` sets the matching `localActive` bit at the next edge. If the same bit is also being cleared by an allowed write in that cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Deactivate-register write strobe |
| wrData | input | 32 | Written value; ID in bits [23:0] |
| intGroup | input | 2 | Group of the written interrupt |
| secDisable | input | 1 | Single security state when 1 |
| excLevel | input | 2 | Current exception level |
| curSecure | input | 1 | Processor in secure state |
| splitEoi | input | 1 | Selected EOI mode splits drop and deactivate |
| el3FiqRoute | input | 1 | FIQ routed to level 3 |
| el3IrqRoute | input | 1 | IRQ routed to level 3 |
| el2FiqRoute | input | 1 | FIQ routed to level 2 |
| el2IrqRoute | input | 1 | IRQ routed to level 2 |
| localActSet | input | 32 | Set pulses for local active bits |
| localActive | output | 32 | Local active bits |
| distClrValid | output | 1 | Distributor active-clear request |
| distClrId | output | 24 | ID of the request |

## Verification
The bench goes after the permission corners where routing bits and security state combine:

- Secure level 1 with group 1 and security enabled must pass. A design that reused the non-secure rule would wrongly refuse it.
- Non-secure level 1 must honour the hypervisor route. A design that swapped the FIQ and IRQ route bits would pass or block the wrong group.

It also probes the ID boundaries at 31/32 and `NUM_IRQ`-1/`NUM_IRQ`. An off-by-one there either clears a local bit for a shared interrupt, or sends the distributor a request for an ID that does not exist.

Further checks cover:

- bits above bit 23 of the written value, which a design that forgot to mask them would turn into an ignored write;
- a set and a clear of the same local bit in one cycle;
- how long the distributor request lasts.

// File: rtl/irq_deact_pkg.sv
package irq_deact_pkg;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  typedef struct packed {
    logic clrLocal;
    logic reqDist;
  } deact_stb_t;

endpackage

// File: rtl/irq_deact_ctrl.sv
module irq_deact_ctrl
  import irq_deact_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 24,
  parameter int LOCAL_N = 32,
  parameter int NUM_IRQ = 256
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  grp_e              grp,
  input  logic              secDisable,
  input  logic [1:0]        excLevel,
  input  logic              curSecure,
  input  logic              splitEoi,
  input  logic              el3FiqRoute,
  input  logic              el3IrqRoute,
  input  logic              el2FiqRoute,
  input  logic              el2IrqRoute,
  output logic [ID_W-1:0]   wrId,
  output deact_stb_t        stb
);
  localparam logic [ID_W-1:0] NUM_ID   = ID_W'(NUM_IRQ);
  localparam logic [ID_W-1:0] LOCAL_ID = ID_W'(LOCAL_N);

  logic isGrp0, isSecIrq, inRange, allowed, fire;

  assign wrId     = wrData[ID_W-1:0];
  assign inRange  = wrId < NUM_ID;
  assign isGrp0   = (grp == GRP_G0);
  assign isSecIrq = !secDisable && (grp != GRP_G1NS);

  always_comb begin
    allowed = 1'b0;
    if (grp != GRP_RSVD) begin
      unique case (excLevel)
        2'd3: allowed = 1'b1;
        2'd2: allowed = (secDisable && isGrp0 && !el3FiqRoute) ||
                        (!isSecIrq && !isGrp0 && !el3IrqRoute);
        2'd1: begin
          if (!curSecure)
            allowed = (secDisable && isGrp0 && !el3FiqRoute && !el2FiqRoute) ||
                      (!isSecIrq && !isGrp0 && !el3IrqRoute && !el2IrqRoute);
          else
            allowed = (isGrp0 && !el3FiqRoute) ||
                      (!isGrp0 && (!isSecIrq || !secDisable) && !el3IrqRoute);
        end
        default: allowed = 1'b0;
      endcase
    end
  end

  assign fire         = wrEn && splitEoi && inRange && allowed;
  assign stb.clrLocal = fire && (wrId <  LOCAL_ID);
  assign stb.reqDist  = fire && (wrId >= LOCAL_ID);

endmodule

// File: rtl/irq_deact_datapath.sv
module irq_deact_datapath
  import irq_deact_pkg::*;
#(
  parameter int ID_W    = 24,
  parameter int LOCAL_N = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  deact_stb_t         stb,
  input  logic [ID_W-1:0]    wrId,
  input  logic [LOCAL_N-1:0] localActSet,
  output logic [LOCAL_N-1:0] localActive,
  output logic               distClrValid,
  output logic [ID_W-1:0]    distClrId
);
  localparam int LIDX_W = $clog2(LOCAL_N);

  logic [LIDX_W-1:0] localIdx;
  assign localIdx = wrId[LIDX_W-1:0];

  for (genvar b = 0; b < LOCAL_N; b++) begin : g_act
    logic clrHit;
    assign clrHit = stb.clrLocal && (localIdx == LIDX_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN)                localActive[b] <= 1'b0;
      else if (clrHit)          localActive[b] <= 1'b0;
      else if (localActSet[b])  localActive[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      distClrValid <= 1'b0;
      distClrId    <= '0;
    end else begin
      distClrValid <= stb.reqDist;
      if (stb.reqDist) distClrId <= wrId;
    end
  end

endmodule

// File: rtl/irq_deact_gate.sv
module irq_deact_gate
  import irq_deact_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 24,
  parameter int LOCAL_N = 32,
  parameter int NUM_IRQ = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [1:0]         intGroup,
  input  logic               secDisable,
  input  logic [1:0]         excLevel,
  input  logic               curSecure,
  input  logic               splitEoi,
  input  logic               el3FiqRoute,
  input  logic               el3IrqRoute,
  input  logic               el2FiqRoute,
  input  logic               el2IrqRoute,
  input  logic [LOCAL_N-1:0] localActSet,
  output logic [LOCAL_N-1:0] localActive,
  output logic               distClrValid,
  output logic [ID_W-1:0]    distClrId
);
  deact_stb_t      stb;
  logic [ID_W-1:0] wrId;

  irq_deact_ctrl #(
    .DATA_W(DATA_W), .ID_W(ID_W), .LOCAL_N(LOCAL_N), .NUM_IRQ(NUM_IRQ)
  ) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .grp(grp_e'(intGroup)),
    .secDisable(secDisable), .excLevel(excLevel), .curSecure(curSecure),
    .splitEoi(splitEoi), .el3FiqRoute(el3FiqRoute), .el3IrqRoute(el3IrqRoute),
    .el2FiqRoute(el2FiqRoute), .el2IrqRoute(el2IrqRoute),
    .wrId(wrId), .stb(stb)
  );

  irq_deact_datapath #(
    .ID_W(ID_W), .LOCAL_N(LOCAL_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrId(wrId),
    .localActSet(localActSet), .localActive(localActive),
    .distClrValid(distClrValid), .distClrId(distClrId)
  );

endmodule

// File: rtl/irq_deact_checker.sv
module irq_deact_checker #(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 24,
  parameter int LOCAL_N = 32,
  parameter int NUM_IRQ = 256
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [1:0]         intGroup,
  input logic [1:0]         excLevel,
  input logic               splitEoi,
  input logic [LOCAL_N-1:0] localActSet,
  input logic [LOCAL_N-1:0] localActive,
  input logic               distClrValid,
  input logic [ID_W-1:0]    distClrId
);
  localparam logic [ID_W-1:0] NUM_ID   = ID_W'(NUM_IRQ);
  localparam logic [ID_W-1:0] LOCAL_ID = ID_W'(LOCAL_N);
  localparam int LIDX_W = $clog2(LOCAL_N);

  logic [ID_W-1:0] id;
  assign id = wrData[ID_W-1:0];

  AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && id >= NUM_ID) |=> !distClrValid); // R1
  AST_NOSPLIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !splitEoi) |=> !distClrValid); // R2
  AST_TOP_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && splitEoi && excLevel == 2'd3 && intGroup != 2'd3 && id < LOCAL_ID)
    |=> !localActive[$past(id[LIDX_W-1:0])]); // R3
  AST_DIST_ID_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    distClrValid |-> (distClrId >= LOCAL_ID && distClrId < NUM_ID)); // R8
  AST_LEVEL0_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (excLevel == 2'd0 || intGroup == 2'd3)) |=> !distClrValid); // R9
  AST_NO_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && localActSet == '0) |=> $stable(localActive)); // R11

endmodule

bind irq_deact_gate irq_deact_checker #(
  .DATA_W(DATA_W), .ID_W(ID_W), .LOCAL_N(LOCAL_N), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .intGroup(intGroup),
  .excLevel(excLevel), .splitEoi(splitEoi), .localActSet(localActSet),
  .localActive(localActive), .distClrValid(distClrValid), .distClrId(distClrId)
);

// File: tb/sim_irq_deact_gate.sv
module sim_irq_deact_gate;
  localparam int NUM_IRQ = 256;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic [1:0]  intGroup, excLevel;
  logic        secDisable, curSecure, splitEoi;
  logic        el3FiqRoute, el3IrqRoute, el2FiqRoute, el2IrqRoute;
  logic [31:0] localActSet;
  logic [31:0] localActive;
  logic        distClrValid;
  logic [23:0] distClrId;

  int errors = 0;
  int checks = 0;
  logic [31:0] modelAct;

  always #4 clk = ~clk;

  irq_deact_gate #(.NUM_IRQ(NUM_IRQ)) u0 (.*);

  function automatic bit expAllowed(logic [1:0] g, logic sd, logic [1:0] lvl,
      logic sec, logic f3, logic i3, logic f2, logic i2);
    bit g0   = (g == 2'd0);
    bit sIrq = !sd && (g != 2'd2);
    if (g == 2'd3) return 0;
    case (lvl)
      2'd3: return 1;
      2'd2: return (sd && g0 && !f3) || (!sIrq && !g0 && !i3);
      2'd1: if (!sec) return (sd && g0 && !f3 && !f2) || (!sIrq && !g0 && !i3 && !i2);
            else      return (g0 && !f3) || (!g0 && (!sIrq || !sd) && !i3);
      default: return 0;
    endcase
  endfunction

  function automatic string reqTag(logic [23:0] id);
    if (id >= 24'(NUM_IRQ)) return "R1";
    if (!splitEoi) return "R2";
    if (excLevel == 2'd0 || intGroup == 2'd3) return "R9";
    if (excLevel == 2'd3) return "R3";
    if (excLevel == 2'd2) return "R4";
    if (!curSecure) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCtx(logic [1:0] g, logic sd, logic [1:0] lvl, logic sec,
      logic sp, logic f3, logic i3, logic f2, logic i2);
    intGroup = g; secDisable = sd; excLevel = lvl; curSecure = sec; splitEoi = sp;
    el3FiqRoute = f3; el3IrqRoute = i3; el2FiqRoute = f2; el2IrqRoute = i2;
  endtask

  // drive at negedge, one edge, compare at next negedge
  task automatic step(logic we, logic [31:0] d, logic [31:0] setv, string tag);
    logic [23:0] id = d[23:0];
    bit ok = we && splitEoi && id < 24'(NUM_IRQ) &&
             expAllowed(intGroup, secDisable, excLevel, curSecure,
                        el3FiqRoute, el3IrqRoute, el2FiqRoute, el2IrqRoute);
    wrEn = we; wrData = d; localActSet = setv;
    modelAct = modelAct | setv;
    if (ok && id < 24'd32) modelAct[id[4:0]] = 1'b0;
    @(negedge clk);
    check({tag, " local"}, 64'(localActive), 64'(modelAct));
    check({tag, " dist"}, 64'(distClrValid), 64'(ok && id >= 24'd32));
    if (ok && id >= 24'd32) check({tag, " distId"}, 64'(distClrId), 64'(id));
    wrEn = 1'b0; localActSet = '0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; localActSet = '0; modelAct = '0;
    setCtx(2'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 local", 64'(localActive), 64'd0);
    check("R10 dist", 64'(distClrValid), 64'd0);
    rstN = 1'b1;

    step(1'b0, 32'd0, 32'hFFFF_FFFF, "R11 set");
    step(1'b1, 32'd5, 32'd0, "R7 clear5");
    step(1'b1, 32'd31, 32'd0, "R7 clear31");
    step(1'b1, 32'd32, 32'd0, "R8 id32");
    step(1'b0, 32'd0, 32'd0, "R8 pulse-ends");
    step(1'b1, 32'(NUM_IRQ - 1), 32'd0, "R8 lastId");
    step(1'b1, 32'(NUM_IRQ), 32'd0, "R1 firstUnimpl");
    step(1'b1, 32'h0100_0007, 32'd0, "R1 upperBits");
    step(1'b1, 32'h00FF_FFFF, 32'd0, "R1 maxId");
    step(1'b1, 32'd9, 32'h0000_0200, "R11 setClrSame");
    setCtx(2'd1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'd3, 32'd0, "R2 notSplit");
    setCtx(2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'd4, 32'd0, "R6 secG1");
    setCtx(2'd2, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 32'd6, 32'd0, "R5 nsG1 fiqHypOnly");
    setCtx(2'd2, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 32'd7, 32'd0, "R5 nsG1 irqHyp");
    setCtx(2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'd8, 32'd0, "R9 level0");
    setCtx(2'd3, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'd10, 32'd0, "R9 rsvdGroup");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [31:0] sv;
      int sel = $urandom_range(0, 9);
      setCtx(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             ($urandom_range(0, 4) != 0), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
      if (sel < 5)      d = {8'($urandom), 24'($urandom_range(0, 31))};
      else if (sel < 9) d = {8'($urandom), 24'($urandom_range(32, NUM_IRQ - 1))};
      else              d = {8'($urandom), 24'($urandom_range(NUM_IRQ, 4095))};
      sv = ($urandom_range(0, 3) == 0) ? 32'($urandom) : 32'd0;
      step(($urandom_range(0, 7) != 0), d, sv, reqTag(d[23:0]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule